// File: doc/BRIEF.md
# Stack Unwind Sequencer

This block restores processor state from a byte-wide stack when a return command arrives. The stack sits in a synchronous memory addressed by an 8-bit stack pointer. A return-from-interrupt command pulls five bytes: the condition-code byte, the accumulator, the index register, the program-counter high byte and the program-counter low byte. A return-from-subroutine command pulls only the two program-counter bytes. A third command puts the stack pointer back at its top value.

For each pull the sequencer first increments the stack pointer and then reads at the new value. It drives a read strobe and a read address, and one cycle later it captures the returned byte into the destination register. Reads go out on consecutive cycles, and the sequence ends with a one-cycle done pulse. While a sequence runs, the block ignores further commands.

Top module: `stack_unwind_seq`

## Requirements
- R1: Command 0x9C, accepted while idle, sets the stack pointer to 0xFF. It changes no restored register, issues no read, and raises done for one cycle on the cycle after acceptance.
- R2: Command 0x80 issues exactly five reads. The captured bytes go to the condition-code, accumulator, index, PC-high and PC-low outputs, in that order.
- R3: Each pull increments the stack pointer and reads at the incremented value. After a sequence the pointer equals its starting value plus the number of pulls.
- R4: Command 0x81 issues exactly two reads, PC-high then PC-low. The condition-code, accumulator and index outputs keep their values.
- R5: Incrementing the stack pointer from 0xFF gives 0x00, so a sequence can read across the top of the address space.
- R6: The read strobe is high for one cycle per pull, and the reads of a sequence go out on consecutive cycles starting the cycle after acceptance. Each byte is taken from the read data one cycle after its strobe.
- R7: A command presented while a sequence is busy has no effect on the reads, the stack pointer or the restored registers.
- R8: Done is high for exactly one cycle, in the cycle after the last byte is captured. Busy falls at the same time. This is cycle 7 after acceptance for 0x80 and cycle 4 for 0x81.
- R9: After synchronous reset the stack pointer is 0xFF, all restored registers are 0x00, and busy, done and the read strobe are low.
- R10: Any other opcode is ignored: no read, no done, no change of the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| stk_rd_en | output | 1 | Stack memory read strobe |
| stk_rd_addr | output | 8 | Stack memory read address |
| stk_rd_data | input | 8 | Stack memory read data, valid one cycle after the strobe |
| busy | output | 1 | Pull sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Current stack pointer |
| ccr | output | 8 | Restored condition-code byte |
| acc | output | 8 | Restored accumulator |
| xr | output | 8 | Restored index register |
| pch | output | 8 | Restored program-counter high byte |
| pcl | output | 8 | Restored program-counter low byte |

## Verification
The bench walks the stack pointer around the whole 256-byte space using a mix of five-pull and two-pull sequences, including runs that cross the top of the space. A design that post-increments the pointer, or does not wrap it, would read the wrong addresses and restore wrong bytes. The bench also offers a pointer-reset command in the middle of a sequence, so a design that accepts commands while busy would show a pointer of 0xFF. It also measures the cycle and width of the done pulse, which catches off-by-one completion timing and captures made a cycle too early. Two-pull returns are checked to leave the flags, accumulator and index untouched.

// File: rtl/stack_unwind_pkg.sv
package stack_unwind_pkg;
  typedef enum logic [2:0] {
    TAG_CCR = 3'd0,
    TAG_A   = 3'd1,
    TAG_X   = 3'd2,
    TAG_PCH = 3'd3,
    TAG_PCL = 3'd4
  } pull_tag_e;

  localparam int NUM_TAGS = 5;

  function automatic pull_tag_e tag_next(input pull_tag_e t);
    return pull_tag_e'(t + 3'd1);
  endfunction
endpackage

// File: rtl/unwind_cmd_decode.sv
module unwind_cmd_decode
  import stack_unwind_pkg::*;
#(
  parameter int          OP_W   = 8,
  parameter logic [7:0]  OP_RTI = 8'h80,
  parameter logic [7:0]  OP_RTS = 8'h81,
  parameter logic [7:0]  OP_RSP = 8'h9C
) (
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  output logic            start_pull,
  output pull_tag_e       first_tag,
  output logic            load_sp
);
  always_comb begin
    start_pull = 1'b0;
    load_sp    = 1'b0;
    first_tag  = TAG_CCR;
    if (cmd_valid) begin
      if (cmd_op == OP_W'(OP_RTI)) begin
        start_pull = 1'b1;
        first_tag  = TAG_CCR;
      end else if (cmd_op == OP_W'(OP_RTS)) begin
        start_pull = 1'b1;
        first_tag  = TAG_PCH;
      end else if (cmd_op == OP_W'(OP_RSP)) begin
        load_sp = 1'b1;
      end
    end
  end
endmodule

// File: rtl/unwind_pull_ctrl.sv
module unwind_pull_ctrl
  import stack_unwind_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SP_TOP = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_pull,
  input  pull_tag_e         first_tag,
  input  logic              load_sp,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              cap_vld_o,
  output pull_tag_e         cap_tag_o
);
  logic              busy_q, iss_act_q, rd_en_q, cap_vld_q, done_q;
  pull_tag_e         iss_tag_q, rd_tag_q, cap_tag_q;
  logic [ADDR_W-1:0] sp_q, rd_addr_q, sp_inc;

  assign sp_inc = sp_q + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      iss_act_q <= 1'b0;
      iss_tag_q <= TAG_CCR;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      rd_tag_q  <= TAG_CCR;
      cap_vld_q <= 1'b0;
      cap_tag_q <= TAG_CCR;
      done_q    <= 1'b0;
      sp_q      <= SP_TOP;
    end else begin
      rd_en_q   <= 1'b0;
      done_q    <= 1'b0;
      cap_vld_q <= rd_en_q;
      cap_tag_q <= rd_tag_q;
      if (!busy_q) begin
        if (start_pull) begin
          busy_q    <= 1'b1;
          rd_en_q   <= 1'b1;
          rd_addr_q <= sp_inc;
          sp_q      <= sp_inc;
          rd_tag_q  <= first_tag;
          iss_act_q <= (first_tag != TAG_PCL);
          iss_tag_q <= tag_next(first_tag);
        end else if (load_sp) begin
          sp_q   <= SP_TOP;
          done_q <= 1'b1;
        end
      end else begin
        if (iss_act_q) begin
          rd_en_q   <= 1'b1;
          rd_addr_q <= sp_inc;
          sp_q      <= sp_inc;
          rd_tag_q  <= iss_tag_q;
          iss_act_q <= (iss_tag_q != TAG_PCL);
          iss_tag_q <= tag_next(iss_tag_q);
        end
        if (cap_vld_q && cap_tag_q == TAG_PCL) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_en_o   = rd_en_q;
  assign rd_addr_o = rd_addr_q;
  assign sp_o      = sp_q;
  assign cap_vld_o = cap_vld_q;
  assign cap_tag_o = cap_tag_q;

  AST_SP_PREINC: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> (rd_addr_q == sp_q) && (sp_q == $past(sp_q) + ADDR_W'(1))); // R3
  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> busy_q); // R6
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(busy_q)) |-> !busy_q); // R8
  AST_RSP_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
    (load_sp && !busy_q) |=> (sp_q == SP_TOP)); // R1
endmodule

// File: rtl/unwind_capture_regs.sv
module unwind_capture_regs
  import stack_unwind_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  pull_tag_e         wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ccr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] xr_o,
  output logic [DATA_W-1:0] pch_o,
  output logic [DATA_W-1:0] pcl_o
);
  logic [DATA_W-1:0] slot_q [NUM_TAGS];

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_tag == pull_tag_e'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign ccr_o = slot_q[TAG_CCR];
  assign acc_o = slot_q[TAG_A];
  assign xr_o  = slot_q[TAG_X];
  assign pch_o = slot_q[TAG_PCH];
  assign pcl_o = slot_q[TAG_PCL];
endmodule

// File: rtl/stack_unwind_seq.sv
module stack_unwind_seq
  import stack_unwind_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter int                OP_W   = 8,
  parameter logic [7:0]        OP_RTI = 8'h80,
  parameter logic [7:0]        OP_RTS = 8'h81,
  parameter logic [7:0]        OP_RSP = 8'h9C,
  parameter logic [ADDR_W-1:0] SP_TOP = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  output logic              stk_rd_en,
  output logic [ADDR_W-1:0] stk_rd_addr,
  input  logic [DATA_W-1:0] stk_rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] ccr,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] xr,
  output logic [DATA_W-1:0] pch,
  output logic [DATA_W-1:0] pcl
);
  logic      start_pull, load_sp, cap_vld;
  pull_tag_e first_tag, cap_tag;

  unwind_cmd_decode #(
    .OP_W(OP_W), .OP_RTI(OP_RTI), .OP_RTS(OP_RTS), .OP_RSP(OP_RSP)
  ) dec_i (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .start_pull(start_pull),
    .first_tag (first_tag),
    .load_sp   (load_sp)
  );

  unwind_pull_ctrl #(.ADDR_W(ADDR_W), .SP_TOP(SP_TOP)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_pull(start_pull),
    .first_tag (first_tag),
    .load_sp   (load_sp),
    .busy_o    (busy),
    .done_o    (done),
    .rd_en_o   (stk_rd_en),
    .rd_addr_o (stk_rd_addr),
    .sp_o      (sp),
    .cap_vld_o (cap_vld),
    .cap_tag_o (cap_tag)
  );

  unwind_capture_regs #(.DATA_W(DATA_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cap_vld),
    .wr_tag (cap_tag),
    .wr_data(stk_rd_data),
    .ccr_o  (ccr),
    .acc_o  (acc),
    .xr_o   (xr),
    .pch_o  (pch),
    .pcl_o  (pcl)
  );

  AST_CCR_ONLY_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    !$stable(ccr) |-> $past(busy)); // R4
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_pull) |=> !stk_rd_en); // R10
endmodule

// File: tb/stack_unwind_seq_tb.sv
module stack_unwind_seq_tb_top;
  localparam logic [7:0] OP_RTI = 8'h80;
  localparam logic [7:0] OP_RTS = 8'h81;
  localparam logic [7:0] OP_RSP = 8'h9C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic       stk_rd_en, busy, done;
  logic [7:0] stk_rd_addr, sp, ccr, acc, xr, pch, pcl;
  logic [7:0] mem_q = 8'h00;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_sp, exp_ccr, exp_acc, exp_xr, exp_pch, exp_pcl;

  always #5 clk = ~clk;

  function automatic logic [7:0] mval(input logic [7:0] a);
    return a * 8'd37 + 8'd91;
  endfunction

  always_ff @(posedge clk) if (stk_rd_en) mem_q <= mval(stk_rd_addr);

  stack_unwind_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .stk_rd_en(stk_rd_en), .stk_rd_addr(stk_rd_addr), .stk_rd_data(mem_q),
    .busy(busy), .done(done), .sp(sp), .ccr(ccr), .acc(acc), .xr(xr),
    .pch(pch), .pcl(pcl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(sp  == exp_sp,  req, "sp",  sp,  exp_sp);
    chk(ccr == exp_ccr, req, "ccr", ccr, exp_ccr);
    chk(acc == exp_acc, req, "acc", acc, exp_acc);
    chk(xr  == exp_xr,  req, "xr",  xr,  exp_xr);
    chk(pch == exp_pch, req, "pch", pch, exp_pch);
    chk(pcl == exp_pcl, req, "pcl", pcl, exp_pcl);
  endtask

  task automatic run_pull(input logic [7:0] op, input int npulls, input bit inject);
    logic [7:0] s0;
    int reads;
    int done_idx;
    string req;
    s0 = exp_sp;
    reads = 0;
    done_idx = 0;
    req = (npulls == 5) ? "R2" : "R4";
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int idx = 1; idx <= npulls + 4; idx++) begin
      if (inject && idx == 2) begin
        cmd_valid = 1'b1;
        cmd_op = OP_RSP;
      end else begin
        cmd_valid = 1'b0;
      end
      if (stk_rd_en) begin
        chk(stk_rd_addr == 8'(s0 + 8'(reads + 1)),
            (s0 > 8'hFF - 8'(npulls)) ? "R5" : "R3", "read address",
            stk_rd_addr, 8'(s0 + 8'(reads + 1)));
        chk(idx == reads + 1, "R6", "read cycle", idx, reads + 1);
        reads++;
      end
      if (done) begin
        if (done_idx == 0) done_idx = idx;
        else chk(1'b0, "R8", "done width", idx, done_idx);
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(reads == npulls, req, "read count", reads, npulls);
    chk(done_idx == npulls + 2, "R8", "done cycle", done_idx, npulls + 2);
    chk(!busy, "R8", "busy after done", busy, 0);
    exp_sp = 8'(s0 + 8'(npulls));
    if (npulls == 5) begin
      exp_ccr = mval(8'(s0 + 8'd1));
      exp_acc = mval(8'(s0 + 8'd2));
      exp_xr  = mval(8'(s0 + 8'd3));
    end
    exp_pch = mval(8'(exp_sp - 8'd1));
    exp_pcl = mval(exp_sp);
    chk_regs(inject ? "R7" : req);
  endtask

  task automatic run_rsp;
    int done_cnt;
    done_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = OP_RSP;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done, "R1", "done after rsp", done, 1);
    chk(!stk_rd_en && !busy, "R1", "no read on rsp", stk_rd_en, 0);
    @(negedge clk);
    chk(!done, "R1", "done width rsp", done, 0);
    exp_sp = 8'hFF;
    chk_regs("R1");
  endtask

  task automatic run_junk(input logic [7:0] op);
    int seen;
    seen = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (stk_rd_en || done || busy) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R10", "activity on unknown op", seen, 0);
    chk(sp == exp_sp, "R10", "sp on unknown op", sp, exp_sp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_sp = 8'hFF;
    exp_ccr = 8'h00; exp_acc = 8'h00; exp_xr = 8'h00;
    exp_pch = 8'h00; exp_pcl = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !stk_rd_en, "R9", "idle after reset", busy, 0);
    chk_regs("R9");
    run_pull(OP_RTI, 5, 1'b0);
    chk(sp == 8'h04, "R5", "sp after wrap", sp, 8'h04);
    run_junk(8'h9D);
    run_junk(8'h00);
    for (int k = 0; k < 90; k++) begin
      if (k % 3 == 0) run_pull(OP_RTS, 2, k % 2 == 1);
      else run_pull(OP_RTI, 5, k % 4 == 1);
    end
    run_rsp();
    run_pull(OP_RTS, 2, 1'b0);
    run_pull(OP_RTI, 5, 1'b1);
    run_rsp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule